// File: doc/BRIEF.md
# Debug Command Argument Collector

This block sits between the byte stream of a serial debug port and the monitor routine that services debug requests on the CPU. While the engine is in debug mode it accepts one command byte and decodes it. Commands that carry arguments then take a fixed number of follow-on bytes, each steered into an address register, a data register or a one-byte password buffer according to its position. When collection ends, a 4-bit command code is published and a one-cycle request vectors the CPU to a fixed monitor entry address, where software finishes the job. The single-step and resume commands are handled here in hardware.

Bytes arrive on a valid/ready stream. A byte is taken on every rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high while the collector is gathering arguments, and while it is idle in debug mode. It is low in background mode and during the one step cycle of a trace. The source must hold `in_valid` and `in_data` steady until the byte is taken. Gaps with `in_valid` low are allowed at any point and do not change state. Debug mode is entered from background with a pulse on `dbg_enter`.

Top module: `dbgc_collector`

## Requirements
- R1: After reset the engine is in background mode: `dbg_active`, `in_ready`, `cpu_step`, `mon_jump` and `pwd_stb` are 0, and `mon_cmd`, `arg_addr`, `arg_data` and `pwd_byte` are all zero.
- R2: A byte is consumed only on an edge where `in_valid` and `in_ready` are both high. `in_ready` is 0 in background mode, and holding `in_valid` high there changes no output.
- R3: Opcode 0x25 takes four follow-on bytes. Byte 0 is written to `arg_addr[7:0]`, byte 1 to `arg_addr[15:8]`, byte 2 to `arg_data[7:0]` and byte 3 to `arg_data[15:8]`. No jump is requested before the fourth byte, even across idle gaps.
- R4: In the cycle after the fourth 0x25 argument is taken, `mon_cmd` equals 4'b0101 and `mon_jump` is 1, with `mon_vector` = 16'h8010.
- R5: Opcode 0x29 takes two follow-on bytes into `arg_addr` (low byte, then high byte) and leaves `arg_data` unchanged. In the cycle after the second byte, `mon_cmd` equals 4'b1001 and `mon_jump` is 1.
- R6: In the cycle after opcode 0x28 is taken, `mon_cmd` equals 4'b1000 and `mon_jump` is 1. The engine then takes 32 bytes. In the cycle after each one, `pwd_byte` holds that byte and `pwd_stb` is 1. No jump follows the last byte, and the engine is idle again.
- R7: In the cycle after opcode 0x26 is taken, `dbg_active` is 0, `cpu_step` is 1 and `in_ready` is 0. In the next cycle `dbg_active` is 1, `cpu_step` is 0 and `in_ready` is 1.
- R8: After opcode 0x27 is taken, `dbg_active` and `in_ready` are 0 from the next cycle until a `dbg_enter` pulse.
- R9: Any opcode other than 0x25 to 0x29 is consumed and ignored. The engine stays idle with `in_ready` high, no jump is requested, and the argument registers and `mon_cmd` keep their values.
- R10: `mon_jump` is high for exactly one cycle per request. `mon_cmd`, `arg_addr` and `arg_data` change only when a later command writes them.
- R11: A `dbg_enter` pulse in background mode sets `dbg_active` in the next cycle. In debug mode it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Collector can take a byte |
| in_data | input | 8 | Command or argument byte |
| dbg_enter | input | 1 | Break request: enter debug mode |
| dbg_active | output | 1 | Engine is in debug mode (CPU halted) |
| cpu_step | output | 1 | One-cycle CPU execution enable during trace |
| mon_jump | output | 1 | One-cycle request to vector the CPU to the monitor |
| mon_vector | output | 16 | Monitor entry address |
| mon_cmd | output | 4 | Command code for the monitor |
| arg_addr | output | 16 | Collected address argument |
| arg_data | output | 16 | Collected data argument |
| pwd_byte | output | 8 | Last password byte received |
| pwd_stb | output | 1 | One-cycle pulse when `pwd_byte` is loaded |

## Verification
A stale or wrong argument index shows up at once as a byte landing in the wrong lane of `arg_addr` or `arg_data`. It can also show as a `mon_jump` that fires one byte early or late, which is visible in the cycle after the last argument. A decode error shows on the very next cycle as a missing or spurious jump, or a wrong `mon_cmd` value, because every one of the 256 opcodes is driven and classified. A faulty trace or return sequencer shows within one or two cycles through `dbg_active`, `cpu_step` and `in_ready`.

// File: rtl/dbgc_pkg.sv
package dbgc_pkg;

  localparam logic [7:0] OP_WMEM   = 8'h25;
  localparam logic [7:0] OP_TRACE  = 8'h26;
  localparam logic [7:0] OP_RETURN = 8'h27;
  localparam logic [7:0] OP_UNLOCK = 8'h28;
  localparam logic [7:0] OP_RREG   = 8'h29;

  localparam logic [3:0] CODE_WMEM   = 4'b0101;
  localparam logic [3:0] CODE_UNLOCK = 4'b1000;
  localparam logic [3:0] CODE_RREG   = 4'b1001;

  typedef enum logic [2:0] {
    K_NONE,
    K_WMEM,
    K_RREG,
    K_UNLOCK,
    K_TRACE,
    K_RETURN
  } kind_e;

  typedef enum logic {
    ST_IDLE,
    ST_COLLECT
  } coll_state_e;

  typedef struct packed {
    kind_e      kind;
    logic       jump_on_start;
    logic       jump_on_end;
    logic       has_args;
    logic [3:0] code;
  } op_info_t;

endpackage

// File: rtl/dbgc_decoder.sv
module dbgc_decoder
  import dbgc_pkg::*;
#(
  parameter int ADDR_B    = 2,
  parameter int DATA_B    = 2,
  parameter int PWD_BYTES = 32,
  parameter int CNT_W     = 6
) (
  input  logic [7:0]       opcode,
  output op_info_t         info,
  output logic [CNT_W-1:0] nargs
);

  always_comb begin
    info  = '{kind: K_NONE, jump_on_start: 1'b0, jump_on_end: 1'b0,
              has_args: 1'b0, code: 4'h0};
    nargs = '0;
    unique case (opcode)
      OP_WMEM: begin
        info.kind        = K_WMEM;
        info.jump_on_end = 1'b1;
        info.has_args    = 1'b1;
        info.code        = CODE_WMEM;
        nargs            = CNT_W'(ADDR_B + DATA_B);
      end
      OP_RREG: begin
        info.kind        = K_RREG;
        info.jump_on_end = 1'b1;
        info.has_args    = 1'b1;
        info.code        = CODE_RREG;
        nargs            = CNT_W'(ADDR_B);
      end
      OP_UNLOCK: begin
        info.kind          = K_UNLOCK;
        info.jump_on_start = 1'b1;
        info.has_args      = 1'b1;
        info.code          = CODE_UNLOCK;
        nargs              = CNT_W'(PWD_BYTES);
      end
      OP_TRACE:  info.kind = K_TRACE;
      OP_RETURN: info.kind = K_RETURN;
      default:   info.kind = K_NONE;
    endcase
  end

  always_comb begin
    assert (!(info.has_args && nargs == '0)) else $error("AST_ARGS_NONZERO"); // R3
    assert (!(info.jump_on_start && info.jump_on_end)) else $error("AST_ONE_JUMP_POINT"); // R10
  end

endmodule

// File: rtl/dbgc_arg_sink.sv
module dbgc_arg_sink
  import dbgc_pkg::*;
#(
  parameter int ADDR_B = 2,
  parameter int DATA_B = 2,
  parameter int CNT_W  = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  kind_e               kind,
  input  logic [CNT_W-1:0]    idx,
  input  logic [7:0]          din,
  output logic [ADDR_B*8-1:0] addr,
  output logic [DATA_B*8-1:0] data,
  output logic [7:0]          pbuf,
  output logic                pstb
);

  logic addr_kind;
  assign addr_kind = (kind == K_WMEM) || (kind == K_RREG);

  for (genvar g = 0; g < ADDR_B; g++) begin : g_alane
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                     q <= 8'h00;
      else if (we && addr_kind && idx == CNT_W'(g))   q <= din;
    end
    assign addr[g*8 +: 8] = q;
  end

  for (genvar g = 0; g < DATA_B; g++) begin : g_dlane
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                                q <= 8'h00;
      else if (we && kind == K_WMEM && idx == CNT_W'(ADDR_B + g)) q <= din;
    end
    assign data[g*8 +: 8] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pbuf <= 8'h00;
      pstb <= 1'b0;
    end else begin
      pstb <= we && kind == K_UNLOCK;
      if (we && kind == K_UNLOCK) pbuf <= din;
    end
  end

  AST_DATA_ONLY_WMEM: assert property (@(posedge clk) disable iff (!rst_n)
    (we && kind != K_WMEM) |=> $stable(data)); // R5
  AST_PSTB_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    pstb |-> $past(we && kind == K_UNLOCK)); // R6

endmodule

// File: rtl/dbgc_run_ctl.sv
module dbgc_run_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic trace_go,
  input  logic return_go,
  input  logic enter,
  output logic active,
  output logic step
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      step   <= 1'b0;
    end else if (trace_go) begin
      active <= 1'b0;
      step   <= 1'b1;
    end else if (step) begin
      active <= 1'b1;
      step   <= 1'b0;
    end else if (return_go) begin
      active <= 1'b0;
    end else if (enter && !active) begin
      active <= 1'b1;
    end
  end

  AST_STEP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (!step && active)); // R7
  AST_STEP_OUT_OF_DEBUG: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> !active); // R7
  AST_RETURN_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
    (return_go && !trace_go) |=> !active); // R8

endmodule

// File: rtl/dbgc_collector.sv
module dbgc_collector
  import dbgc_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 16,
  parameter int          PWD_BYTES = 32,
  parameter logic [15:0] MON_VEC   = 16'h8010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic              dbg_enter,
  output logic              dbg_active,
  output logic              cpu_step,
  output logic              mon_jump,
  output logic [15:0]       mon_vector,
  output logic [3:0]        mon_cmd,
  output logic [ADDR_W-1:0] arg_addr,
  output logic [DATA_W-1:0] arg_data,
  output logic [7:0]        pwd_byte,
  output logic              pwd_stb
);

  localparam int ADDR_B   = ADDR_W / 8;
  localparam int DATA_B   = DATA_W / 8;
  localparam int MAX_ARGS = (PWD_BYTES > ADDR_B + DATA_B) ? PWD_BYTES : ADDR_B + DATA_B;
  localparam int CNT_W    = $clog2(MAX_ARGS + 1);

  coll_state_e      state_q;
  kind_e            kind_q;
  logic [CNT_W-1:0] nargs_q, idx_q;
  logic             jend_q;
  logic [3:0]       code_q;

  op_info_t         info;
  logic [CNT_W-1:0] nargs;
  logic             fire, op_take, arg_take, last_arg;
  logic             trace_go, return_go;

  dbgc_decoder #(
    .ADDR_B(ADDR_B), .DATA_B(DATA_B), .PWD_BYTES(PWD_BYTES), .CNT_W(CNT_W)
  ) u_dec (
    .opcode(in_data),
    .info  (info),
    .nargs (nargs)
  );

  assign in_ready  = (state_q == ST_COLLECT) || dbg_active;
  assign fire      = in_valid && in_ready;
  assign op_take   = fire && state_q == ST_IDLE;
  assign arg_take  = fire && state_q == ST_COLLECT;
  assign last_arg  = idx_q == nargs_q - CNT_W'(1);
  assign trace_go  = op_take && info.kind == K_TRACE;
  assign return_go = op_take && info.kind == K_RETURN;
  assign mon_vector = MON_VEC;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      kind_q   <= K_NONE;
      nargs_q  <= '0;
      idx_q    <= '0;
      jend_q   <= 1'b0;
      code_q   <= 4'h0;
      mon_cmd  <= 4'h0;
      mon_jump <= 1'b0;
    end else begin
      mon_jump <= 1'b0;
      if (op_take) begin
        if (info.has_args) begin
          state_q <= ST_COLLECT;
          kind_q  <= info.kind;
          nargs_q <= nargs;
          idx_q   <= '0;
          jend_q  <= info.jump_on_end;
          code_q  <= info.code;
        end
        if (info.jump_on_start) begin
          mon_cmd  <= info.code;
          mon_jump <= 1'b1;
        end
      end else if (arg_take) begin
        idx_q <= idx_q + CNT_W'(1);
        if (last_arg) begin
          state_q <= ST_IDLE;
          kind_q  <= K_NONE;
          if (jend_q) begin
            mon_cmd  <= code_q;
            mon_jump <= 1'b1;
          end
        end
      end
    end
  end

  dbgc_arg_sink #(
    .ADDR_B(ADDR_B), .DATA_B(DATA_B), .CNT_W(CNT_W)
  ) u_sink (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (arg_take),
    .kind (kind_q),
    .idx  (idx_q),
    .din  (in_data),
    .addr (arg_addr),
    .data (arg_data),
    .pbuf (pwd_byte),
    .pstb (pwd_stb)
  );

  dbgc_run_ctl u_run (
    .clk      (clk),
    .rst_n    (rst_n),
    .trace_go (trace_go),
    .return_go(return_go),
    .enter    (dbg_enter),
    .active   (dbg_active),
    .step     (cpu_step)
  );

  AST_JUMP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    mon_jump |=> !mon_jump); // R10
  AST_CMD_ONLY_WITH_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
    !mon_jump |-> $stable(mon_cmd)); // R10
  AST_JUMP_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    mon_jump |-> $past(fire)); // R2
  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_COLLECT) |-> (idx_q < nargs_q)); // R3
  AST_COLLECT_IN_DEBUG: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_COLLECT) |-> dbg_active); // R2

endmodule

// File: tb/dbgc_collector_test.sv
`timescale 1ns/1ps
module dbgc_collector_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        dbg_enter = 1'b0;
  logic        in_ready, dbg_active, cpu_step, mon_jump, pwd_stb;
  logic [15:0] mon_vector, arg_addr, arg_data;
  logic [3:0]  mon_cmd;
  logic [7:0]  pwd_byte;

  int tests = 0;
  int fails = 0;
  logic done = 1'b0;

  logic [15:0] exp_addr = 16'h0, exp_data = 16'h0;
  logic [3:0]  exp_cmd = 4'h0;

  always #2 clk = ~clk;

  dbgc_collector uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .dbg_enter(dbg_enter), .dbg_active(dbg_active),
    .cpu_step(cpu_step), .mon_jump(mon_jump), .mon_vector(mon_vector),
    .mon_cmd(mon_cmd), .arg_addr(arg_addr), .arg_data(arg_data),
    .pwd_byte(pwd_byte), .pwd_stb(pwd_stb)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic enter_dbg();
    @(negedge clk);
    dbg_enter = 1'b1;
    @(negedge clk);
    dbg_enter = 1'b0;
    chk(dbg_active == 1'b1, "R11 enter", 32'(dbg_active), 32'd1);
  endtask

  task automatic check_regs(input string req);
    chk(arg_addr == exp_addr, req, 32'(arg_addr), 32'(exp_addr));
    chk(arg_data == exp_data, req, 32'(arg_data), 32'(exp_data));
    chk(mon_cmd == exp_cmd, req, 32'(mon_cmd), 32'(exp_cmd));
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(dbg_active == 0 && in_ready == 0 && cpu_step == 0, "R1 ctl", 32'({dbg_active, in_ready, cpu_step}), 32'd0);
    chk(mon_jump == 0 && pwd_stb == 0 && pwd_byte == 0, "R1 pulses", 32'({mon_jump, pwd_stb, pwd_byte}), 32'd0);
    check_regs("R1 regs");
    rst_n = 1'b1;

    // R2 background mode: valid held high, nothing taken
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 8'h25;
    repeat (3) begin
      @(negedge clk);
      chk(in_ready == 0, "R2 ready in background", 32'(in_ready), 32'd0);
      chk(mon_jump == 0 && dbg_active == 0, "R2 no effect", 32'({mon_jump, dbg_active}), 32'd0);
    end
    in_valid = 1'b0;
    check_regs("R2 regs");
    enter_dbg();
    // R11 enter while in debug has no effect
    enter_dbg();
    chk(in_ready == 1, "R11 idle ready", 32'(in_ready), 32'd1);

    for (int op = 0; op < 256; op++) begin
      logic [7:0] o;
      o = 8'(op);
      if (!dbg_active) enter_dbg();
      send(o);
      case (o)
        8'h25: begin
          logic [15:0] a, d;
          a = {o ^ 8'hC3, 8'(op * 5 + 1)};
          d = {~o, 8'(op * 3 + 7)};
          chk(mon_jump == 0 && in_ready == 1, "R3 after opcode", 32'({mon_jump, in_ready}), 32'd1);
          send(a[7:0]);
          send(a[15:8]);
          repeat (3) @(negedge clk);
          chk(mon_jump == 0, "R3 no early jump across gap", 32'(mon_jump), 32'd0);
          send(d[7:0]);
          chk(mon_jump == 0, "R3 no jump on byte 2", 32'(mon_jump), 32'd0);
          send(d[15:8]);
          exp_addr = a; exp_data = d; exp_cmd = 4'b0101;
          chk(mon_jump == 1, "R4 jump", 32'(mon_jump), 32'd1);
          chk(mon_vector == 16'h8010, "R4 vector", 32'(mon_vector), 32'h8010);
          check_regs("R3 R4 regs");
          @(negedge clk);
          chk(mon_jump == 0, "R10 jump one cycle", 32'(mon_jump), 32'd0);
        end
        8'h29: begin
          logic [15:0] a;
          a = {8'(op + 17), o ^ 8'h96};
          send(a[7:0]);
          chk(mon_jump == 0, "R5 no early jump", 32'(mon_jump), 32'd0);
          send(a[15:8]);
          exp_addr = a; exp_cmd = 4'b1001;
          chk(mon_jump == 1, "R5 jump", 32'(mon_jump), 32'd1);
          check_regs("R5 regs");
          @(negedge clk);
          chk(mon_jump == 0, "R10 jump one cycle", 32'(mon_jump), 32'd0);
        end
        8'h28: begin
          exp_cmd = 4'b1000;
          chk(mon_jump == 1, "R6 jump at opcode", 32'(mon_jump), 32'd1);
          chk(mon_cmd == 4'b1000, "R6 code", 32'(mon_cmd), 32'h8);
          for (int i = 0; i < 32; i++) begin
            logic [7:0] b;
            b = 8'(i * 7 + 3);
            send(b);
            chk(pwd_stb == 1 && pwd_byte == b, "R6 byte", 32'({pwd_stb, pwd_byte}), 32'({1'b1, b}));
            chk(mon_jump == 0, "R6 no jump per byte", 32'(mon_jump), 32'd0);
          end
          @(negedge clk);
          chk(pwd_stb == 0 && mon_jump == 0, "R6 end quiet", 32'({pwd_stb, mon_jump}), 32'd0);
          check_regs("R10 regs held after unlock");
          // next byte must be treated as an opcode: 0x00 is ignored
          send(8'h00);
          chk(pwd_stb == 0 && mon_jump == 0, "R6 back to idle", 32'({pwd_stb, mon_jump}), 32'd0);
        end
        8'h26: begin
          chk(dbg_active == 0 && cpu_step == 1 && in_ready == 0, "R7 step cycle",
              32'({dbg_active, cpu_step, in_ready}), 32'b010);
          @(negedge clk);
          chk(dbg_active == 1 && cpu_step == 0 && in_ready == 1, "R7 reentry",
              32'({dbg_active, cpu_step, in_ready}), 32'b101);
        end
        8'h27: begin
          chk(dbg_active == 0 && in_ready == 0, "R8 left debug", 32'({dbg_active, in_ready}), 32'd0);
          repeat (3) @(negedge clk);
          chk(dbg_active == 0 && in_ready == 0 && cpu_step == 0, "R8 stays out",
              32'({dbg_active, in_ready, cpu_step}), 32'd0);
        end
        default: begin
          chk(mon_jump == 0 && in_ready == 1, "R9 ignored", 32'({mon_jump, in_ready}), 32'd1);
          @(negedge clk);
          chk(mon_jump == 0 && in_ready == 1 && dbg_active == 1, "R9 still idle",
              32'({mon_jump, in_ready, dbg_active}), 32'b011);
          check_regs("R9 R10 regs");
        end
      endcase
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule